// File: doc/BRIEF.md
# System Clock Rate Monitor

This block checks that the system clock runs at or above a minimum rate. A slow reference tick arrives from an independent clock domain. The block counts system-clock edges between successive rising edges of that tick. A window shorter than a parameterised number of system clocks means the clock is too slow. When that happens, an active-low error pin is driven low and a status flag is set.

The monitor is armed as it leaves reset. While reset is held it is inhibited: the error pin stays high and the flag reads as set. The state machine leaves reset in its fault state. If the clock is not yet up to speed, the error is therefore visible on the first cycle after reset. The error is released only after a hold-off once the frequency is good. A fixed hold-off counter follows the first good measurement. Because the measurement window lands at an arbitrary point, the release falls 16 to 32 system cycles after the tick edge that ends that first good window.

The controller has three states: FAULT, HOLD and RUN. FAULT is the reset state; the error is driven and the monitor waits for a good window. HOLD counts the hold-off with the error still driven. RUN means the error is released. The transitions are:
- FAULT→HOLD on a good measurement.
- HOLD→RUN when the hold-off count completes.
- HOLD→FAULT on a slow measurement.
- RUN→FAULT on a slow measurement.
- Every other case stays in the current state.

Top module: `clock_rate_monitor`

## Requirements
- R1: While `rst_n` is low, `err_n` is 1 and `cm_flag` is 1.
- R2: On the first clock after `rst_n` goes high, `err_n` is 0 and `cm_flag` is 1 (the FAULT state), with no reference tick needed.
- R3: A window is the number of system clocks between two successive rising edges of `ref_tick`. A window of at least `MIN_COUNT` clocks (default 20) is good, and a shorter window is slow. With the default setting, 20 is good and 19 is slow.
- R4: From FAULT, a good window does not release the error at once. `err_n` rises between 16 and 32 system clocks after the rising tick edge that ends the first good window, following a hold-off of `HOLD_CYCLES` (default 16) clocks.
- R5: While released (RUN), a slow window drives `err_n` low and sets `cm_flag` within a few clocks of the tick edge that ends it.
- R6: A slow window measured during the hold-off returns the block to FAULT, and the error is not released.
- R7: The first rising tick edge after reset only opens a window. No judgement is made on it, however long reset was released before it.
- R8: `cm_flag` is 1 exactly while `err_n` is 0 after reset. It is cleared only when the error is released.
- R9: A tick held high for many clocks counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock under test |
| rst_n | input | 1 | Asynchronous active-low internal reset |
| ref_tick | input | 1 | Slow reference tick from another clock domain |
| err_n | output | 1 | Active-low clock-rate error |
| cm_flag | output | 1 | Monitor status: 1 = armed or error pending, 0 = released |

## Verification
The bench probes the good/slow boundary at 20 and 19 clocks. A comparator off by one would release the error or fault on the wrong side of it. It times the release after the first good window. A design without a hold-off, or with the wrong one, would fall outside the 16–32 cycle span. It sends a slow window into the hold-off, which a design without the abort path would miss: that design would release anyway. It also checks that a tick after a long idle spell following reset is not judged, since counting from reset would release falsely. Finally, it holds the tick high for a long time; a level-sensitive detector would see a stream of zero-length windows and raise a false fault.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        ST_FAULT = 2'b00,
        ST_HOLD  = 2'b01,
        ST_RUN   = 2'b10
    } cm_state_e;

endpackage

// File: rtl/clkmon_tick_sync.sv
module clkmon_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        tick_rise = sync_q[STAGES-1] & ~prev_q;
    end

    // R9: a held level yields one edge only
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

endmodule

// File: rtl/clkmon_window_meter.sv
module clkmon_window_meter #(
    parameter int MIN_COUNT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_rise,
    output logic meas_valid,
    output logic meas_good
);

    localparam int CNT_W = $clog2(MIN_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_COUNT);
    localparam logic [CNT_W-1:0] GOOD_MIN = CNT_W'(MIN_COUNT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // counter of clocks since last edge, saturating at the threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_rise) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // first edge after reset only opens a window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (tick_rise) begin
            primed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_valid <= 1'b0;
            meas_good  <= 1'b0;
        end else begin
            meas_valid <= tick_rise & primed_q;
            if (tick_rise) begin
                meas_good <= (cnt_q >= GOOD_MIN);
            end
        end
    end

    // R3: counter never passes its saturation value
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_SAT);

    // R7: an edge before priming produces no verdict
    a_r7_first_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_rise && !primed_q) |=> !meas_valid);

endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
    import clkmon_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meas_valid,
    input  logic meas_good,
    output logic err_n,
    output logic cm_flag
);

    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

    cm_state_e        state_q, state_d;
    logic [HOLD_W-1:0] hold_q;
    logic              win_good, win_slow;

    always_comb begin
        win_good = meas_valid &  meas_good;
        win_slow = meas_valid & ~meas_good;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAULT: if (win_good) state_d = ST_HOLD;
            ST_HOLD: begin
                if (win_slow)                state_d = ST_FAULT;
                else if (hold_q == HOLD_LAST) state_d = ST_RUN;
            end
            ST_RUN:   if (win_slow) state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAULT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q != ST_HOLD) begin
            hold_q <= '0;
        end else if (hold_q != HOLD_LAST) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // outputs; the monitor is inhibited while reset is held
    always_comb begin
        err_n   = 1'b1;
        cm_flag = 1'b1;
        if (rst_n) begin
            unique case (state_q)
                ST_RUN:  begin err_n = 1'b1; cm_flag = 1'b0; end
                ST_HOLD: begin err_n = 1'b0; cm_flag = 1'b1; end
                default: begin err_n = 1'b0; cm_flag = 1'b1; end
            endcase
        end
    end

    // R5: a slow window while released faults next cycle
    a_r5_slow_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && win_slow) |=> (state_q == ST_FAULT));

    // R6: a slow window during hold-off aborts the release
    a_r6_hold_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && win_slow) |=> (state_q == ST_FAULT));

    // R4: release only out of HOLD after the full hold-off
    a_r4_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
            ($past(state_q) == ST_HOLD && $past(hold_q) == HOLD_LAST));

    // R8: flag and error pin agree once out of reset
    a_r8_flag_tracks_err: assert property (@(posedge clk) disable iff (!rst_n)
        cm_flag == !err_n);

    // R4: without a good window FAULT is held
    a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !win_good) |=> (state_q == ST_FAULT));

endmodule

// File: rtl/clock_rate_monitor.sv
module clock_rate_monitor #(
    parameter int MIN_COUNT   = 20,
    parameter int HOLD_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic err_n,
    output logic cm_flag
);

    logic tick_rise;
    logic meas_valid;
    logic meas_good;

    clkmon_tick_sync #(
        .STAGES     (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (ref_tick),
        .tick_rise  (tick_rise)
    );

    clkmon_window_meter #(
        .MIN_COUNT  (MIN_COUNT)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_rise  (tick_rise),
        .meas_valid (meas_valid),
        .meas_good  (meas_good)
    );

    clkmon_ctrl #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_good  (meas_good),
        .err_n      (err_n),
        .cm_flag    (cm_flag)
    );

    // R1: inhibited during reset
    always_comb begin
        if (!rst_n) a_r1_reset_quiet: assert (err_n && cm_flag);
    end

endmodule

// File: tb/clock_rate_monitor_bench.sv
`timescale 1ns/1ps
module clock_rate_monitor_bench;

    localparam int MIN_COUNT = 20;
    localparam int NVEC = 6;
    localparam int VEC_P [NVEC] = '{8, 30, 19, 20, 12, 50};
    localparam int VEC_E [NVEC] = '{0,  1,  0,  1,  0,  1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic err_n, cm_flag;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    clock_rate_monitor #(.MIN_COUNT(MIN_COUNT), .HOLD_CYCLES(16), .SYNC_STAGES(2))
        u_clock_rate_monitor (
            .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
            .err_n(err_n), .cm_flag(cm_flag));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one window: rising edge, high for hi cycles, total p cycles
    task automatic send_window(input int p, input int hi);
        @(negedge clk) ref_tick = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk) ref_tick = 1'b0;
        repeat (p - hi - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        ref_tick = 1'b0;
        repeat (4) @(negedge clk);
        check(err_n == 1'b1, "R1 err_n in reset", int'(err_n), 1);
        check(cm_flag == 1'b1, "R1 flag in reset", int'(cm_flag), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_n == 1'b0, "R2 err_n after reset", int'(err_n), 0);
        check(cm_flag == 1'b1, "R2 flag after reset", int'(cm_flag), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R3 R5 R8: table of steady window lengths
        send_window(40, 3); // primes the first window
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < 4; k++) send_window(VEC_P[i], 3);
            check(int'(err_n) == VEC_E[i], $sformatf("R3/R5 err_n period %0d", VEC_P[i]),
                  int'(err_n), VEC_E[i]);
            check(int'(cm_flag) == 1 - VEC_E[i], $sformatf("R8 flag period %0d", VEC_P[i]),
                  int'(cm_flag), 1 - VEC_E[i]);
        end

        // R9: long high level in RUN is one edge
        send_window(60, 45);
        send_window(60, 3);
        check(err_n == 1'b1, "R9 long high level", int'(err_n), 1);

        // R1 R2: reset while released
        do_reset();

        // R7: long idle after reset, single edge is not judged
        repeat (100) @(negedge clk);
        send_window(100, 3);
        check(err_n == 1'b0, "R7 first edge not judged", int'(err_n), 0);
        check(cm_flag == 1'b1, "R7 flag still set", int'(cm_flag), 1);

        // R4: hold-off timing after first good window
        do_reset();
        send_window(40, 3);
        begin
            int n = 0;
            bit early = 1'b0;
            @(negedge clk) ref_tick = 1'b1;
            while (n < 40 && err_n == 1'b0) begin
                @(negedge clk);
                n++;
                if (n == 3) ref_tick = 1'b0;
                if (n < 16 && err_n) early = 1'b1;
            end
            check(!early, "R4 no early release", int'(early), 0);
            check(n >= 16 && n <= 32, "R4 release delay", n, 16);
            repeat (30) @(negedge clk);
        end

        // R6: slow window inside hold-off aborts release
        do_reset();
        send_window(40, 3);
        send_window(8, 3);
        send_window(60, 3);
        check(err_n == 1'b0, "R6 hold-off aborted", int'(err_n), 0);
        check(cm_flag == 1'b1, "R6 flag kept", int'(cm_flag), 1);

        // R3 boundary again from FAULT: exactly MIN_COUNT releases
        for (int k = 0; k < 4; k++) send_window(MIN_COUNT, 3);
        check(err_n == 1'b1, "R3 boundary 20 good", int'(err_n), 1);
        for (int k = 0; k < 2; k++) send_window(MIN_COUNT - 1, 3);
        check(err_n == 1'b0, "R5 boundary 19 slow", int'(err_n), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule